// File: doc/BRIEF.md
# Start-Triggered Counter Flag Sequencer

The block is a small controller and datapath pair. A 4-bit up-counter runs while two single-bit flags follow it. One flag (E) tracks the counter's weight-4 bit. The other flag (F) marks the end of a run. A one-cycle start request in the idle state clears the counter and the end flag, then starts counting on every clock.

The block tests two counter bits on each clock: the weight-4 bit (bit 2) and the weight-8 bit (bit 3). It tests them at the same edge that increments the counter, and it reads the values held before that edge. When both bits are high, the controller enters a one-cycle finish state. That state raises the end flag, and the block then falls back to idle, where the result stays on the outputs until the next start.

A surrounding controller uses the block as a timed sequence generator. It pulses start and waits for the end flag.

Top module: `flag_seq_top`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes idle (code 2'b00), and `cnt_q`, `e_q` and `f_q` become 0.
- R2: In idle with `start` low, `cnt_q`, `e_q`, `f_q` and the state keep their values at the next edge.
- R3: In idle with `start` high, the next edge clears `cnt_q` and `f_q`, leaves `e_q` unchanged and moves to the count state (code 2'b01).
- R4: In the count state, `cnt_q` increases by one at every edge.
- R5: In the count state, if bit 2 of `cnt_q` is 0 before the edge, `e_q` becomes 0 and the state stays count.
- R6: In the count state, if bit 2 is 1 and bit 3 is 0 before the edge, `e_q` becomes 1 and the state stays count.
- R7: In the count state, if bits 2 and 3 are both 1 before the edge, `e_q` becomes 1 and the state moves to finish (code 2'b11). Both tests use the pre-increment value.
- R8: In the finish state, the next edge sets `f_q` to 1, keeps `cnt_q` and `e_q`, and returns to idle.
- R9: `start` has no effect in the count and finish states.
- R10: After a run, idle holds `cnt_q` = 4'b1101, `e_q` = 1 and `f_q` = 1 until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start request, sampled in idle |
| cnt_q | output | 4 | Counter value |
| e_q | output | 1 | Flag that follows counter bit 2 |
| f_q | output | 1 | End-of-run flag |
| state_q | output | 2 | Control state: 00 idle, 01 count, 11 finish |

## Verification
The counter increment and the flag and state decisions fall in the same edge. The decisions must read the counter before that edge.

The bench steers runs through counter value 1100. Value 1100 triggers the exit while the counter moves to 1101, so the state must turn to finish at that exact edge with the counter at 1101. A design that tested the post-increment value would leave at a different count, and the per-cycle comparison against the bench's reference model flags that at once.

Start is also held high across a whole run and pulsed inside the count and finish states. This shows that start only restarts from idle, right after the end flag rises.

// File: rtl/flag_seq_pkg.sv
package flag_seq_pkg;

    localparam int CNT_W    = 4;
    localparam int E_BIT    = 2;  // counter bit that drives the E flag
    localparam int STOP_BIT = 3;  // counter bit that, with E_BIT, ends the run

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_COUNT  = 2'b01,
        ST_FINISH = 2'b11
    } seq_state_t;

    typedef struct packed {
        logic clear;   // clear counter and end flag
        logic count;   // increment counter, update E flag
        logic finish;  // set end flag
    } seq_ctl_t;

    function automatic logic at_stop(input logic [CNT_W-1:0] v);
        return v[E_BIT] & v[STOP_BIT];
    endfunction

endpackage

// File: rtl/flag_seq_ctrl.sv
module flag_seq_ctrl
    import flag_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       bit_e,
    input  logic       bit_stop,
    output seq_state_t state,
    output seq_ctl_t   ctl
);

    seq_state_t nxt;

    always_comb begin
        nxt = state;
        ctl = '0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    ctl.clear = 1'b1;
                    nxt       = ST_COUNT;
                end
            end
            ST_COUNT: begin
                ctl.count = 1'b1;
                if (bit_e && bit_stop) nxt = ST_FINISH;
            end
            ST_FINISH: begin
                ctl.finish = 1'b1;
                nxt        = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start) |=> state == ST_IDLE);

    // R3
    start_go_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=> state == ST_COUNT);

    // R7
    stop_go_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT && bit_e && bit_stop) |=> state == ST_FINISH);

    // R8
    finish_back_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_FINISH |=> state == ST_IDLE);

    // R9
    one_action_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.clear, ctl.count, ctl.finish}));

endmodule

// File: rtl/flag_seq_dp.sv
module flag_seq_dp
    import flag_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  seq_ctl_t         ctl,
    output logic [CNT_W-1:0] cnt,
    output logic             e_flag,
    output logic             f_flag,
    output logic             bit_e,
    output logic             bit_stop
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            e_flag <= 1'b0;
            f_flag <= 1'b0;
        end else begin
            if (ctl.clear) begin
                cnt    <= '0;
                f_flag <= 1'b0;
            end
            if (ctl.count) begin
                cnt    <= cnt + ONE;
                e_flag <= cnt[E_BIT];
            end
            if (ctl.finish) f_flag <= 1'b1;
        end
    end

    assign bit_e    = cnt[E_BIT];
    assign bit_stop = cnt[STOP_BIT];

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.count |=> cnt == $past(cnt) + ONE);

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.clear |=> (cnt == '0 && !f_flag));

    // R8
    finish_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.finish |=> (f_flag && $stable(cnt) && $stable(e_flag)));

    // R2
    idle_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl == '0) |=> ($stable(cnt) && $stable(e_flag) && $stable(f_flag)));

endmodule

// File: rtl/flag_seq_top.sv
module flag_seq_top
    import flag_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic [CNT_W-1:0] cnt_q,
    output logic             e_q,
    output logic             f_q,
    output logic [1:0]       state_q
);

    seq_state_t st;
    seq_ctl_t   ctl;
    logic       b_e, b_stop;

    flag_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .bit_e    (b_e),
        .bit_stop (b_stop),
        .state    (st),
        .ctl      (ctl)
    );

    flag_seq_dp u_dp (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .cnt      (cnt_q),
        .e_flag   (e_q),
        .f_flag   (f_q),
        .bit_e    (b_e),
        .bit_stop (b_stop)
    );

    assign state_q = st;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (state_q == 2'b00 && cnt_q == '0 && !e_q && !f_q));

    // R10
    end_value_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(f_q) |-> (cnt_q == 4'b1101 && e_q && state_q == 2'b00));

endmodule

// File: tb/flag_seq_top_test.sv
module flag_seq_top_test;

    typedef struct {
        logic [3:0] a;
        logic       e;
        logic       f;
        logic [1:0] st;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] cnt_q;
    logic       e_q, f_q;
    logic [1:0] state_q;

    int tests = 0;
    int fails = 0;
    exp_t sb[$];

    // reference model state
    logic [3:0] m_a = '0;
    logic       m_e = 1'b0;
    logic       m_f = 1'b0;
    logic [1:0] m_st = 2'b00;

    always #2 clk = ~clk;

    flag_seq_top uut (
        .clk(clk), .rst(rst), .start(start),
        .cnt_q(cnt_q), .e_q(e_q), .f_q(f_q), .state_q(state_q)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // driver: apply inputs for the next edge and push the predicted result
    task automatic step(input logic r, input logic s);
        exp_t x;
        @(negedge clk);
        rst = r;
        start = s;
        x.tag = "";
        if (r) begin
            m_st = 2'b00; m_a = '0; m_e = 1'b0; m_f = 1'b0; x.tag = "R1";
        end else begin
            case (m_st)
                2'b00: if (s) begin
                    m_a = '0; m_f = 1'b0; m_st = 2'b01; x.tag = "R3";
                end else x.tag = "R2/R10";
                2'b01: begin
                    if (!m_a[2]) begin
                        m_e = 1'b0; x.tag = "R4/R5";
                    end else if (!m_a[3]) begin
                        m_e = 1'b1; x.tag = "R4/R6";
                    end else begin
                        m_e = 1'b1; m_st = 2'b11; x.tag = "R4/R7";
                    end
                    m_a = m_a + 4'd1;
                    if (s) x.tag = {x.tag, "/R9"};
                end
                default: begin
                    m_f = 1'b1; m_st = 2'b00;
                    x.tag = s ? "R8/R9" : "R8";
                end
            endcase
        end
        x.a = m_a; x.e = m_e; x.f = m_f; x.st = m_st;
        sb.push_back(x);
    endtask

    // monitor: compare once the edge has settled
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t x;
                x = sb.pop_front();
                chk(x.tag, "cnt_q", int'(cnt_q), int'(x.a));
                chk(x.tag, "e_q", int'(e_q), int'(x.e));
                chk(x.tag, "f_q", int'(f_q), int'(x.f));
                chk(x.tag, "state_q", int'(state_q), int'(x.st));
            end
        end
    end

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);   // R1
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0);   // R2 idle hold
        step(1'b0, 1'b1);                               // R3 first start
        for (int i = 0; i < 16; i++) step(1'b0, (i == 5 || i == 13)); // R9 pulses
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        @(negedge clk);
        chk("R10", "end cnt_q", int'(cnt_q), 13);
        chk("R10", "end f_q", int'(f_q), 1);
        chk("R10", "end e_q", int'(e_q), 1);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0);   // R10 result held
        // second run with start held through the whole run and beyond
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1);
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0);
        // reset in the middle of a run
        step(1'b0, 1'b1);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
        step(1'b1, 1'b0);                               // R1
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        for (int i = 0; i < 18; i++) step(1'b0, 1'b0);
        repeat (3) @(posedge clk);
        #1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule